// File: doc/BRIEF.md
# Register Negate-and-Flag Execution Unit

This block runs one two-byte register-to-register instruction: it negates a 32-bit general register in two's complement and stores the result in another register of a sixteen-entry file. A single instruction word arrives with a valid strobe. The unit decodes it, reads the named source, writes the negation into the named target, and sets a two-bit condition code from the result.

The most negative input cannot be negated. For that input the unit stores the wrapped value and reports a dedicated overflow code. When the caller's overflow-enable input is set, it also raises a one-cycle exception pulse. The unit does not execute any other opcode. It flags such a word as illegal and leaves the register file and condition code as they were.

A debug port lets an outside agent preload any register while no instruction is presented. The same port reads any register back combinationally.

Top module: `lcr_exec_unit`

## Requirements
- R1: The instruction word is 16 bits wide. Bits [15:8] hold the opcode, and the only executable value is 8'h13. Bits [7:4] name the target register and bits [3:0] name the source register. The words 16'h1326, 16'h1392 and 16'h13FA negate R6 into R2, R2 into R9 and R10 into R15.
- R2: An executed instruction writes the 32-bit two's-complement negation of the source into the target on the clock edge where the strobe is sampled. No other register changes.
- R3: Register 0 is an ordinary operand as target and as source.
- R4: When target equals source, the register ends holding the negation of its own earlier value.
- R5: Without overflow, the condition code becomes 0 for a zero result, 1 for a negative result and 2 for a positive result. It changes on the same edge as the register write.
- R6: A source of 32'h80000000 gives a stored result of 32'h80000000 and a condition code of 3.
- R7: `ovf_exc` is high for the one cycle after an executed overflowing instruction, and only if `pm_ovf_en` was high with it.
- R8: A strobed word with an opcode other than 8'h13 writes no register and leaves the condition code unchanged. It raises `illegal_op` for the one following cycle and never raises `ovf_exc`.
- R9: Synchronous active-low reset clears the condition code, both pulses and all registers to zero.
- R10: The debug port writes `dbg_wdata` into `dbg_addr` on an edge where `dbg_we` is high and `instr_valid` is low. The debug write is ignored while `instr_valid` is high. `dbg_rdata` always shows the register at `dbg_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_valid | input | 1 | Instruction word strobe |
| instr_word | input | 16 | Instruction word: opcode, target and source fields |
| pm_ovf_en | input | 1 | Enables the overflow exception |
| dbg_we | input | 1 | Debug register write enable |
| dbg_addr | input | 4 | Debug register index |
| dbg_wdata | input | 32 | Debug write data |
| dbg_rdata | output | 32 | Contents of the register at dbg_addr |
| cond_code | output | 2 | Condition code from the last executed instruction |
| ovf_exc | output | 1 | One-cycle overflow exception pulse |
| illegal_op | output | 1 | One-cycle illegal-opcode pulse |

## Verification
A swapped or misdecoded register field shows on the debug read of the target right after the executing edge, either as a stale value or as a change in some other register. A wrong condition code or exception pulse is visible at the ports in the cycle after the strobe. Unwanted state carried between instructions shows up in the next instruction that reads the damaged register. The bench therefore reads back the target, the source and an untouched neighbour after every instruction, and samples both pulses in the following cycle as well.

// File: rtl/lcr_pkg.sv
// Shared definitions for the register negate unit.
// Assumes the opcode field is one byte and sits above two register fields.
package lcr_pkg;
    localparam logic [7:0] OPC_NEGATE = 8'h13;

    typedef enum logic [1:0] {
        CC_ZERO = 2'd0,
        CC_NEG  = 2'd1,
        CC_POS  = 2'd2,
        CC_OVF  = 2'd3
    } cc_e;
endpackage

// File: rtl/lcr_decode.sv
// Splits the instruction word into opcode, target and source fields.
// Assumes the layout opcode | target | source, from MSB to LSB.
module lcr_decode #(
    parameter int AW = 4,
    localparam int IW = 8 + 2 * AW
) (
    input  logic [IW-1:0] word,
    output logic          is_negate,
    output logic [AW-1:0] tgt_idx,
    output logic [AW-1:0] src_idx
);
    // Field extraction and opcode match
    always_comb begin
        is_negate = (word[IW-1 -: 8] == lcr_pkg::OPC_NEGATE);
        tgt_idx   = word[2*AW-1 -: AW];
        src_idx   = word[AW-1:0];
    end
endmodule

// File: rtl/lcr_regfile.sv
// General register file: one write port and two combinational read ports.
// Assumes the caller resolves which agent owns the write port.
module lcr_regfile #(
    parameter int DW    = 32,
    parameter int NREGS = 16,
    localparam int AW   = $clog2(NREGS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr_a,
    output logic [DW-1:0] rdata_a,
    input  logic [AW-1:0] raddr_b,
    output logic [DW-1:0] rdata_b
);
    logic [DW-1:0] regs [NREGS];

    for (genvar g = 0; g < NREGS; g++) begin : g_reg
        // One storage word: cleared by reset, loaded when addressed
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[g] <= '0;
            else if (we && (waddr == AW'(g)))
                regs[g] <= wdata;
        end
    end

    // Read ports
    always_comb begin
        rdata_a = regs[raddr_a];
        rdata_b = regs[raddr_b];
    end
endmodule

// File: rtl/lcr_negate.sv
// Two's-complement negation with condition-code classification.
// Assumes the result wraps on the most negative input, which it flags.
module lcr_negate #(
    parameter int DW = 32
) (
    input  logic          [DW-1:0] operand,
    output logic          [DW-1:0] result,
    output logic                   overflow,
    output lcr_pkg::cc_e           cc
);
    localparam logic [DW-1:0] MOST_NEG = {1'b1, {(DW-1){1'b0}}};

    // Negate and classify the result
    always_comb begin
        result   = ~operand + DW'(1);
        overflow = (operand == MOST_NEG);
        if (overflow)
            cc = lcr_pkg::CC_OVF;
        else if (result == '0)
            cc = lcr_pkg::CC_ZERO;
        else if (result[DW-1])
            cc = lcr_pkg::CC_NEG;
        else
            cc = lcr_pkg::CC_POS;
    end
endmodule

// File: rtl/lcr_exec_unit.sv
// Top of the register negate unit: decode, register file, negate and flags.
// Executes in one clock. An instruction owns the write port; the debug port
// writes only when no instruction is strobed. Reset is synchronous, active low.
module lcr_exec_unit #(
    parameter int DW    = 32,
    parameter int NREGS = 16,
    localparam int AW   = $clog2(NREGS),
    localparam int IW   = 8 + 2 * AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          instr_valid,
    input  logic [IW-1:0] instr_word,
    input  logic          pm_ovf_en,
    input  logic          dbg_we,
    input  logic [AW-1:0] dbg_addr,
    input  logic [DW-1:0] dbg_wdata,
    output logic [DW-1:0] dbg_rdata,
    output logic [1:0]    cond_code,
    output logic          ovf_exc,
    output logic          illegal_op
);
    import lcr_pkg::*;

    logic          is_negate;
    logic [AW-1:0] tgt_idx;
    logic [AW-1:0] src_idx;
    logic [DW-1:0] src_value;
    logic [DW-1:0] neg_value;
    logic          neg_ovf;
    cc_e           neg_cc;
    cc_e           cc_q;
    logic          exec;
    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wr_data;

    lcr_decode #(.AW(AW)) u_decode (
        .word      (instr_word),
        .is_negate (is_negate),
        .tgt_idx   (tgt_idx),
        .src_idx   (src_idx)
    );

    lcr_regfile #(.DW(DW), .NREGS(NREGS)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (wr_en),
        .waddr   (wr_addr),
        .wdata   (wr_data),
        .raddr_a (src_idx),
        .rdata_a (src_value),
        .raddr_b (dbg_addr),
        .rdata_b (dbg_rdata)
    );

    lcr_negate #(.DW(DW)) u_neg (
        .operand  (src_value),
        .result   (neg_value),
        .overflow (neg_ovf),
        .cc       (neg_cc)
    );

    // Write-port arbitration: the instruction wins, debug only when idle
    always_comb begin
        exec    = instr_valid && is_negate;
        wr_en   = exec || (dbg_we && !instr_valid);
        wr_addr = exec ? tgt_idx   : dbg_addr;
        wr_data = exec ? neg_value : dbg_wdata;
    end

    // Condition code and one-cycle status pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cc_q       <= CC_ZERO;
            ovf_exc    <= 1'b0;
            illegal_op <= 1'b0;
        end else begin
            ovf_exc    <= exec && neg_ovf && pm_ovf_en;
            illegal_op <= instr_valid && !is_negate;
            if (exec)
                cc_q <= neg_cc;
        end
    end

    assign cond_code = cc_q;
endmodule

// File: rtl/lcr_exec_chk.sv
// Property checker for the register negate unit, bound to the top.
// Assumes the default 16-bit instruction layout with the opcode in the top byte.
module lcr_exec_chk #(
    parameter int DW = 32,
    parameter int IW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          instr_valid,
    input logic [IW-1:0] instr_word,
    input logic          pm_ovf_en,
    input logic [DW-1:0] src_value,
    input logic [1:0]    cond_code,
    input logic          ovf_exc,
    input logic          illegal_op
);
    logic is_op;
    assign is_op = (instr_word[IW-1 -: 8] == 8'h13);

    AST_OVERFLOW_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        instr_valid && is_op && src_value == {1'b1, {(DW-1){1'b0}}} |=> cond_code == 2'd3); // R6
    AST_ZERO_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        instr_valid && is_op && src_value == '0 |=> cond_code == 2'd0); // R5
    AST_EXC_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        instr_valid && !pm_ovf_en |=> !ovf_exc); // R7
    AST_EXC_WITH_OVF_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_exc |-> cond_code == 2'd3); // R7
    AST_ILLEGAL_HOLDS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        instr_valid && !is_op |=> illegal_op && !ovf_exc && $stable(cond_code)); // R8
    AST_NO_SPURIOUS_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_valid |=> !illegal_op && !ovf_exc); // R8
    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> cond_code == 2'd0 && !ovf_exc && !illegal_op); // R9
endmodule

bind lcr_exec_unit lcr_exec_chk #(.DW(DW), .IW(IW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_valid (instr_valid),
    .instr_word  (instr_word),
    .pm_ovf_en   (pm_ovf_en),
    .src_value   (src_value),
    .cond_code   (cond_code),
    .ovf_exc     (ovf_exc),
    .illegal_op  (illegal_op)
);

// File: tb/lcr_exec_unit_tb.sv
// Directed bench for the register negate unit: one task per scenario.
module lcr_exec_unit_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [15:0] instr_word = '0;
    logic        pm_ovf_en = 1'b0;
    logic        dbg_we = 1'b0;
    logic [3:0]  dbg_addr = '0;
    logic [31:0] dbg_wdata = '0;
    logic [31:0] dbg_rdata;
    logic [1:0]  cond_code;
    logic        ovf_exc;
    logic        illegal_op;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lcr_exec_unit u_dut (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_word(instr_word),
        .pm_ovf_en(pm_ovf_en), .dbg_we(dbg_we), .dbg_addr(dbg_addr),
        .dbg_wdata(dbg_wdata), .dbg_rdata(dbg_rdata), .cond_code(cond_code),
        .ovf_exc(ovf_exc), .illegal_op(illegal_op)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input int idx, output logic [31:0] val);
        dbg_addr = 4'(idx);
        #1;
        val = dbg_rdata;
    endtask

    task automatic wr(input int idx, input logic [31:0] val);
        @(negedge clk);
        dbg_we = 1'b1; dbg_addr = 4'(idx); dbg_wdata = val;
        @(negedge clk);
        dbg_we = 1'b0;
    endtask

    // Strobe one word for one cycle; returns at the following negedge
    task automatic run(input logic [15:0] w);
        @(negedge clk);
        instr_valid = 1'b1; instr_word = w;
        @(negedge clk);
        instr_valid = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        chk("R9 cc", 32'(cond_code), 0);
        chk("R9 ovf_exc", 32'(ovf_exc), 0);
        chk("R9 illegal_op", 32'(illegal_op), 0);
        for (int i = 0; i < 16; i++) begin
            rd(i, v);
            chk("R9 register", v, 0);
        end
    endtask

    task automatic t_encodings();
        logic [31:0] v;
        wr(6, 32'd5);
        wr(7, 32'h0BAD_CAFE);
        run(16'h1326);
        rd(2, v); chk("R1 R2 1326 target", v, 32'hFFFF_FFFB);
        rd(6, v); chk("R2 source kept", v, 32'd5);
        rd(7, v); chk("R2 neighbour kept", v, 32'h0BAD_CAFE);
        chk("R5 negative cc", 32'(cond_code), 1);
        run(16'h1392);
        rd(9, v); chk("R1 1392 target", v, 32'd5);
        chk("R5 positive cc", 32'(cond_code), 2);
        wr(10, 32'd0);
        run(16'h13FA);
        rd(15, v); chk("R1 13FA target", v, 32'd0);
        chk("R5 zero cc", 32'(cond_code), 0);
    endtask

    task automatic t_reg_zero();
        logic [31:0] v;
        wr(1, 32'd1);
        run(16'h1301);
        rd(0, v); chk("R3 reg0 as target", v, 32'hFFFF_FFFF);
        wr(1, 32'd99);
        run(16'h1310);
        rd(1, v); chk("R3 reg0 as source", v, 32'd1);
    endtask

    task automatic t_same_reg();
        logic [31:0] v;
        wr(3, 32'd100);
        run(16'h1333);
        rd(3, v); chk("R4 self negate", v, 32'hFFFF_FF9C);
        wr(3, 32'h7FFF_FFFF);
        run(16'h1333);
        rd(3, v); chk("R4 max positive", v, 32'h8000_0001);
        chk("R5 max positive cc", 32'(cond_code), 1);
        chk("R7 no exc without overflow", 32'(ovf_exc), 0);
    endtask

    task automatic t_overflow();
        logic [31:0] v;
        wr(4, 32'h8000_0000);
        pm_ovf_en = 1'b0;
        run(16'h1354);
        rd(5, v); chk("R6 wrapped result", v, 32'h8000_0000);
        chk("R6 overflow cc", 32'(cond_code), 3);
        chk("R7 masked exc", 32'(ovf_exc), 0);
        pm_ovf_en = 1'b1;
        run(16'h1354);
        chk("R7 exc pulse", 32'(ovf_exc), 1);
        @(negedge clk);
        chk("R7 exc one cycle", 32'(ovf_exc), 0);
        pm_ovf_en = 1'b0;
    endtask

    task automatic t_illegal();
        logic [31:0] v;
        wr(8, 32'd7);
        run(16'h1388);
        chk("R2 setup cc", 32'(cond_code), 1);
        wr(7, 32'h0000_1234);
        pm_ovf_en = 1'b1;
        run(16'h1A74);
        chk("R8 illegal pulse", 32'(illegal_op), 1);
        chk("R8 no exc", 32'(ovf_exc), 0);
        chk("R8 cc kept", 32'(cond_code), 1);
        rd(7, v); chk("R8 no write", v, 32'h0000_1234);
        @(negedge clk);
        chk("R8 illegal one cycle", 32'(illegal_op), 0);
        pm_ovf_en = 1'b0;
    endtask

    task automatic t_debug_blocked();
        logic [31:0] v;
        wr(11, 32'h1111_1111);
        wr(12, 32'd3);
        @(negedge clk);
        instr_valid = 1'b1; instr_word = 16'h13DC;
        dbg_we = 1'b1; dbg_addr = 4'd11; dbg_wdata = 32'hDEAD_BEEF;
        @(negedge clk);
        instr_valid = 1'b0; dbg_we = 1'b0;
        rd(11, v); chk("R10 debug write ignored", v, 32'h1111_1111);
        rd(13, v); chk("R10 instruction wins", v, 32'hFFFF_FFFD);
        @(negedge clk);
        instr_valid = 1'b1; instr_word = 16'hFF00;
        dbg_we = 1'b1; dbg_addr = 4'd11; dbg_wdata = 32'hDEAD_BEEF;
        @(negedge clk);
        instr_valid = 1'b0; dbg_we = 1'b0;
        rd(11, v); chk("R10 ignored with illegal word", v, 32'h1111_1111);
    endtask

    task automatic t_midrun_reset();
        chk("R9 cc before reset", 32'(cond_code), 1);
        t_reset();
    endtask

    initial begin
        repeat (2) @(negedge clk);
        t_reset();
        t_encodings();
        t_reg_zero();
        t_same_reg();
        t_overflow();
        t_illegal();
        t_debug_blocked();
        t_midrun_reset();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule